// File: doc/BRIEF.md
# L2 Cache Maintenance Sequencer

This block runs one bulk maintenance operation over a contiguous range of L2 cache lines. Software sets up a first line tag and a line count in a 64-bit range register. It then writes a command register that carries the operation kind and a start or abort command. The sequencer walks the range one 64-byte line at a time. For each line it raises a request that carries the operation kind and the line's byte address, and it holds that request until the cache side acknowledges it. An acknowledge may flag an error.

While the walk is in progress, a busy bit reads as 1. When the walk ends, a three-bit result code tells a normal finish from an abort, and a clean run from one that saw an error. The two registers sit at fixed offsets on a simple write-strobe and combinational-read register port. Software uses the sequencer by polling the busy bit and then reading the result.

Top module: `l2_maint_seq`

## Requirements
- R1: After reset the command register reads 0x8000_0000, the range register reads 0, and `req_valid_o` is 0.
- R2: Command register (offset 0x620) layout. The command is in bits 1:0, with 1 = start and 3 = abort; this field always reads 0. The operation kind is in bits 4:2. Busy is bit 5. The result is in bits 8:6. Bit 31 is a constant 1 that marks the unit as present. All other bits read 0. A write while not busy stores the operation kind.
- R3: Range register (offset 0x628) layout. The line count is in bits 63:48 and the first line tag is in bits 47:6. Bits 5:0 read 0, and written fields read back unchanged.
- R4: A start command accepted while not busy sets busy in the next cycle. It then presents a request whose kind is the stored operation kind and whose address is the first tag times 64. `req_valid_o` is never 1 while not busy.
- R5: Each acknowledge advances the request address by 64. The acknowledge of the last counted line clears busy in the next cycle, with result 1 (done, no error).
- R6: An acknowledge that flags an error makes the final result 2 (done with error) or 4 (aborted with error). This holds for every later line of the same operation, even when those lines are acknowledged without an error.
- R7: A start command written while busy is ignored. The operation kind and the request sequence are unchanged. An abort command written while not busy is ignored, and the result is unchanged.
- R8: An abort written while busy lets the outstanding request stay valid until it is acknowledged. That acknowledge clears busy with result 3 (aborted, no error), and no further request is issued.
- R9: A start with a line count of 0 issues no request and ends at once, with result 1 and busy 0 in the next cycle.
- R10: An accepted start clears the result to 0 and clears any error seen by the previous operation.
- R11: While `req_valid_o` is 1 and no acknowledge arrives, the request address and kind stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_ofs_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data (combinational on offset) |
| req_valid_o | output | 1 | Line request valid |
| req_type_o | output | 3 | Operation kind of the line request |
| req_addr_o | output | 48 | Byte address of the line |
| req_ack_i | input | 1 | Line request acknowledge |
| req_err_i | input | 1 | Error flag qualified by acknowledge |

## Verification
A wrong line counter shows up at the ports as a run that is one line short or one line long. The bench sees this on the acknowledge cycle when busy should clear. A sticky error flag that is lost or left stale shows up only in the final result code, so each error scenario finishes its walk and then reads the command register. A command accepted in the wrong state changes the request address, the stored kind, or the result within one cycle, and the next port sample catches it.

// File: rtl/l2_maint_seq_pkg.sv
package l2_maint_seq_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_START = 2'd1,
    CMD_RSVD  = 2'd2,
    CMD_ABORT = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    RES_NONE     = 3'd0,
    RES_DONE_OK  = 3'd1,
    RES_DONE_ERR = 3'd2,
    RES_ABRT_OK  = 3'd3,
    RES_ABRT_ERR = 3'd4
  } res_e;

  // command register field positions
  localparam int CMD_LSB  = 0;
  localparam int KIND_LSB = 2;
  localparam int BUSY_BIT = 5;
  localparam int RES_LSB  = 6;
  localparam int PRES_BIT = 31;
endpackage

// File: rtl/l2_maint_seq_cfg.sv
module l2_maint_seq_cfg #(
  parameter int TAG_W      = 42,
  parameter int CNT_W      = 16,
  parameter int LINE_SHIFT = 6,
  localparam int CNT_LSB   = LINE_SHIFT + TAG_W,
  localparam int DATA_W    = CNT_LSB + CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              range_we_i,
  input  logic              kind_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [2:0]        kind_o
);
  import l2_maint_seq_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_o  <= '0;
      cnt_o  <= '0;
      kind_o <= '0;
    end else begin
      if (range_we_i) begin
        tag_o <= wdata_i[CNT_LSB-1:LINE_SHIFT];
        cnt_o <= wdata_i[DATA_W-1:CNT_LSB];
      end
      if (kind_we_i) kind_o <= wdata_i[KIND_LSB+:3];
    end
  end
endmodule

// File: rtl/l2_maint_seq_engine.sv
module l2_maint_seq_engine #(
  parameter int TAG_W = 42,
  parameter int CNT_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ctrl_we_i,
  input  l2_maint_seq_pkg::cmd_e      cmd_i,
  input  logic [TAG_W-1:0]            cfg_tag_i,
  input  logic [CNT_W-1:0]            cfg_cnt_i,
  input  logic                        ack_i,
  input  logic                        err_i,
  output logic                        busy_o,
  output l2_maint_seq_pkg::res_e      res_o,
  output logic [TAG_W-1:0]            cur_tag_o
);
  import l2_maint_seq_pkg::*;

  localparam logic [TAG_W-1:0] TAG_ONE = TAG_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] remain_q;
  logic             err_q, abort_q;
  logic             start_ok, abort_cmd, abort_now, err_now, last_line;

  assign start_ok  = ctrl_we_i && (cmd_i == CMD_START) && !busy_o;
  assign abort_cmd = ctrl_we_i && (cmd_i == CMD_ABORT);
  assign abort_now = abort_q || abort_cmd;
  assign err_now   = err_q || err_i;
  assign last_line = (remain_q == CNT_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      res_o     <= RES_NONE;
      cur_tag_o <= '0;
      remain_q  <= '0;
      err_q     <= 1'b0;
      abort_q   <= 1'b0;
    end else if (start_ok) begin
      err_q     <= 1'b0;
      abort_q   <= 1'b0;
      cur_tag_o <= cfg_tag_i;
      remain_q  <= cfg_cnt_i;
      if (cfg_cnt_i == '0) begin
        res_o <= RES_DONE_OK;
      end else begin
        res_o  <= RES_NONE;
        busy_o <= 1'b1;
      end
    end else if (busy_o) begin
      if (ack_i) begin
        err_q     <= err_now;
        cur_tag_o <= cur_tag_o + TAG_ONE;
        remain_q  <= remain_q - CNT_ONE;
        if (abort_now) begin
          busy_o  <= 1'b0;
          abort_q <= 1'b0;
          res_o   <= err_now ? RES_ABRT_ERR : RES_ABRT_OK;
        end else if (last_line) begin
          busy_o <= 1'b0;
          res_o  <= err_now ? RES_DONE_ERR : RES_DONE_OK;
        end
      end else if (abort_cmd) begin
        abort_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/l2_maint_seq.sv
module l2_maint_seq #(
  parameter int            TAG_W      = 42,
  parameter int            CNT_W      = 16,
  parameter int            LINE_SHIFT = 6,
  parameter int            OFS_W      = 12,
  parameter logic [11:0]   CTRL_OFS   = 12'h620,
  parameter logic [11:0]   RANGE_OFS  = 12'h628,
  localparam int           ADDR_W     = TAG_W + LINE_SHIFT,
  localparam int           DATA_W     = ADDR_W + CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [OFS_W-1:0]  reg_ofs_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              req_valid_o,
  output logic [2:0]        req_type_o,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              req_ack_i,
  input  logic              req_err_i
);
  import l2_maint_seq_pkg::*;

  logic             sel_ctrl, sel_range, ctrl_we, range_we;
  cmd_e             cmd;
  logic             busy;
  res_e             res;
  logic [2:0]       op_kind;
  logic [TAG_W-1:0] cfg_tag, cur_tag;
  logic [CNT_W-1:0] cfg_cnt;

  assign sel_ctrl  = (reg_ofs_i == OFS_W'(CTRL_OFS));
  assign sel_range = (reg_ofs_i == OFS_W'(RANGE_OFS));
  assign ctrl_we   = reg_we_i && sel_ctrl;
  assign range_we  = reg_we_i && sel_range;
  assign cmd       = cmd_e'(reg_wdata_i[CMD_LSB+:2]);

  l2_maint_seq_cfg #(.TAG_W(TAG_W), .CNT_W(CNT_W), .LINE_SHIFT(LINE_SHIFT)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .range_we_i (range_we),
    .kind_we_i  (ctrl_we && !busy),
    .wdata_i    (reg_wdata_i),
    .tag_o      (cfg_tag),
    .cnt_o      (cfg_cnt),
    .kind_o     (op_kind)
  );

  l2_maint_seq_engine #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (ctrl_we),
    .cmd_i     (cmd),
    .cfg_tag_i (cfg_tag),
    .cfg_cnt_i (cfg_cnt),
    .ack_i     (req_ack_i),
    .err_i     (req_err_i),
    .busy_o    (busy),
    .res_o     (res),
    .cur_tag_o (cur_tag)
  );

  assign req_valid_o = busy;
  assign req_type_o  = op_kind;
  assign req_addr_o  = {cur_tag, {LINE_SHIFT{1'b0}}};

  always_comb begin
    reg_rdata_o = '0;
    if (sel_ctrl) begin
      reg_rdata_o[PRES_BIT]      = 1'b1;
      reg_rdata_o[RES_LSB+:3]    = res;
      reg_rdata_o[BUSY_BIT]      = busy;
      reg_rdata_o[KIND_LSB+:3]   = op_kind;
    end else if (sel_range) begin
      reg_rdata_o = {cfg_cnt, cfg_tag, {LINE_SHIFT{1'b0}}};
    end
  end
endmodule

// File: rtl/l2_maint_seq_chk.sv
module l2_maint_seq_chk #(
  parameter int ADDR_W     = 48,
  parameter int LINE_SHIFT = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we,
  input logic [1:0]        cmd,
  input logic              busy,
  input logic [2:0]        res,
  input logic [2:0]        op_kind,
  input logic              req_valid_o,
  input logic [2:0]        req_type_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic              req_ack_i
);
  localparam logic [ADDR_W-1:0] LINE_BYTES = ADDR_W'(1) << LINE_SHIFT;

  // R4
  valid_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !req_valid_o);

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ack_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_type_o));

  // R5
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ack_i |=> !req_valid_o || (req_addr_o == $past(req_addr_o) + LINE_BYTES));

  // R10
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> res == 3'd0);

  // R7
  kind_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && ctrl_we && cmd == 2'd1 |=> $stable(op_kind));
endmodule

bind l2_maint_seq l2_maint_seq_chk #(.ADDR_W(ADDR_W), .LINE_SHIFT(LINE_SHIFT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we     (ctrl_we),
  .cmd         (cmd),
  .busy        (busy),
  .res         (res),
  .op_kind     (op_kind),
  .req_valid_o (req_valid_o),
  .req_type_o  (req_type_o),
  .req_addr_o  (req_addr_o),
  .req_ack_i   (req_ack_i)
);

// File: tb/l2_maint_seq_tb_top.sv
module l2_maint_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] CTRL  = 12'h620;
  localparam logic [11:0] RANGE = 12'h628;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_ofs = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        req_valid;
  logic [2:0]  req_type;
  logic [47:0] req_addr;
  logic        req_ack = 1'b0;
  logic        req_err = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2_maint_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_ofs_i(reg_ofs),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .req_valid_o(req_valid),
    .req_type_o(req_type), .req_addr_o(req_addr), .req_ack_i(req_ack), .req_err_i(req_err)
  );

  function automatic logic [63:0] ctrl_val(int res, int busy, int kind);
    return 64'h8000_0000 | (64'(res) << 6) | (64'(busy) << 5) | (64'(kind) << 2);
  endfunction

  function automatic logic [63:0] range_val(logic [15:0] cnt, logic [41:0] tag);
    return {cnt, tag, 6'b0};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] ofs, logic [63:0] d);
    reg_we = 1'b1; reg_ofs = ofs; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [11:0] ofs, output logic [63:0] d);
    reg_ofs = ofs;
    #1 d = reg_rdata;
  endtask

  task automatic ack(logic e);
    req_ack = 1'b1; req_err = e;
    @(negedge clk);
    req_ack = 1'b0; req_err = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    rd(CTRL, d);  chk("R1 ctrl", d, 64'h8000_0000);
    rd(RANGE, d); chk("R1 range", d, 64'h0);
    chk("R1 valid", 64'(req_valid), 64'h0);
  endtask

  task automatic t_regs();
    logic [63:0] d;
    wr(RANGE, {16'd7, 42'h123_4567, 6'h3F});
    rd(RANGE, d); chk("R3 readback", d, range_val(16'd7, 42'h123_4567));
    wr(CTRL, 64'h0000_0000_0000_0014);
    rd(CTRL, d); chk("R2 kind store", d, ctrl_val(0, 0, 5));
  endtask

  task automatic t_run();
    logic [63:0] d;
    logic [41:0] tag = 42'h2_0000_0010;
    wr(RANGE, range_val(16'd3, tag));
    wr(CTRL, 64'((6 << 2) | 1));
    rd(CTRL, d); chk("R4 busy after start", d, ctrl_val(0, 1, 6));
    chk("R4 req kind", 64'(req_type), 64'd6);
    for (int i = 0; i < 3; i++) begin
      chk("R5 req valid", 64'(req_valid), 64'd1);
      chk("R5 req addr", 64'(req_addr), 64'({tag + 42'(i), 6'b0}));
      ack(1'b0);
    end
    rd(CTRL, d); chk("R5 done ok", d, ctrl_val(1, 0, 6));
    chk("R5 valid dropped", 64'(req_valid), 64'd0);
  endtask

  task automatic t_err();
    logic [63:0] d;
    wr(RANGE, range_val(16'd2, 42'h55));
    wr(CTRL, 64'((4 << 2) | 1));
    ack(1'b1);
    rd(CTRL, d); chk("R6 still busy", d, ctrl_val(0, 1, 4));
    ack(1'b0);
    rd(CTRL, d); chk("R6 done err sticky", d, ctrl_val(2, 0, 4));
    // fresh start clears result and error
    wr(RANGE, range_val(16'd1, 42'h56));
    wr(CTRL, 64'((4 << 2) | 1));
    rd(CTRL, d); chk("R10 result cleared", d, ctrl_val(0, 1, 4));
    ack(1'b0);
    rd(CTRL, d); chk("R10 error cleared", d, ctrl_val(1, 0, 4));
  endtask

  task automatic t_ignore_start();
    logic [63:0] d;
    logic [41:0] tag = 42'h100;
    wr(RANGE, range_val(16'd3, tag));
    wr(CTRL, 64'((5 << 2) | 1));
    ack(1'b0);
    wr(RANGE, range_val(16'd9, 42'h900));
    wr(CTRL, 64'((2 << 2) | 1));
    rd(CTRL, d); chk("R7 kind unchanged", d, ctrl_val(0, 1, 5));
    chk("R7 addr unchanged", 64'(req_addr), 64'({tag + 42'd1, 6'b0}));
    ack(1'b0);
    chk("R7 sequence continues", 64'(req_addr), 64'({tag + 42'd2, 6'b0}));
    ack(1'b0);
    rd(CTRL, d); chk("R7 original count", d, ctrl_val(1, 0, 5));
  endtask

  task automatic t_abort();
    logic [63:0] d;
    wr(RANGE, range_val(16'd4, 42'h200));
    wr(CTRL, 64'((7 << 2) | 1));
    ack(1'b0);
    wr(CTRL, 64'((7 << 2) | 3));
    chk("R8 request held", 64'(req_valid), 64'd1);
    chk("R8 held addr", 64'(req_addr), 64'({42'h201, 6'b0}));
    ack(1'b0);
    rd(CTRL, d); chk("R8 aborted ok", d, ctrl_val(3, 0, 7));
    chk("R8 no more requests", 64'(req_valid), 64'd0);
    wr(RANGE, range_val(16'd5, 42'h300));
    wr(CTRL, 64'((7 << 2) | 1));
    ack(1'b1);
    wr(CTRL, 64'((7 << 2) | 3));
    ack(1'b0);
    rd(CTRL, d); chk("R6 aborted with error", d, ctrl_val(4, 0, 7));
    wr(CTRL, 64'((7 << 2) | 3));
    rd(CTRL, d); chk("R7 idle abort ignored", d, ctrl_val(4, 0, 7));
    chk("R7 idle abort no request", 64'(req_valid), 64'd0);
  endtask

  task automatic t_zero();
    logic [63:0] d;
    wr(RANGE, range_val(16'd0, 42'h400));
    wr(CTRL, 64'((1 << 2) | 1));
    chk("R9 no request", 64'(req_valid), 64'd0);
    rd(CTRL, d); chk("R9 immediate done", d, ctrl_val(1, 0, 1));
    @(negedge clk);
    chk("R9 stays idle", 64'(req_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_run();
    t_err();
    t_ignore_start();
    t_abort();
    t_zero();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule